// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the interrupt entry and return sequences of a simple 16-bit real-mode processor. It watches several request classes and chooses the most urgent one. For that request it saves the flags word, the code segment and the instruction pointer on the stack through a word-wide memory port. It then clears the interrupt-enable and trap flags and fetches the handler's IP and CS from a vector table at the bottom of memory. A return request runs the reverse: it pops IP, CS and flags back off the stack.

The processor core gives its current CS, IP, SS, SP and flags on the `cur*` inputs. The block takes a copy of them in the cycle it accepts a request. The updated register values appear on the `cpu*` outputs and are valid when `done` pulses.

A reset request is a special case. It does not touch memory. It forces CS=FFFFh, IP=0000h and flags=0 at once, even in the middle of a sequence.

Top module: `intSeq`

## Requirements
- R1: When the block is idle, a request is chosen in this order: reset request first, then internal exception (`excReq`), then software interrupt (`swReq`), then non-maskable interrupt (`nmiReq`), then maskable hardware interrupt (`hwReq`), and last a return request (`retReq`). The other requests in that cycle are dropped.
- R2: An entry sequence does five bus transfers in this order: write the flags word, write CS, write IP, read the new IP, read the new CS. The three written values are the ones sampled from `curFlags`, `curCs` and `curIp` at acceptance.
- R3: Each push first lowers SP by 2. It then writes to the 20-bit address SS×16+SP. After an entry, `cpuSp` equals the accepted SP minus 6.
- R4: After an entry, bit 9 (interrupt enable) and bit 8 (trap) of `cpuFlags` are 0, and every other bit keeps its accepted value. While `curFlags` bit 9 is 0, `hwReq` is ignored: there is no busy, no bus transfer and no register change.
- R5: The vector reads use byte address type×4 for IP and type×4+2 for CS. `cpuIp` and `cpuCs` take the read data. The type comes from `excType`, `swType` or `hwType` for those classes, and is fixed at 2 for the non-maskable interrupt.
- R6: A return reads IP, then CS, then flags. Each read is at SS×16+SP, and SP rises by 2 after each read. The `cpu*` outputs then hold the popped values, and `cpuSp` equals the accepted SP plus 6.
- R7: A reset request in any state gives the following on the next clock: `cpuCs`=FFFFh, `cpuIp`=0, `cpuFlags`=0, `busy` low and `done` high. In the cycle it is present, `memValid` is low. Block reset (`rstN` low) leaves the same register values, with `busy` and `done` both low.
- R8: A transfer completes on a clock where `memValid` and `memReady` are both high. While `memReady` is low, `memValid`, `memWrite`, `memAddr` and `memWdata` hold steady.
- R9: `busy` goes high on the clock that accepts a request and stays high until the last transfer. `done` is a one-cycle pulse on that clock, and `busy` is low in the same cycle. `memValid` is never high while `busy` is low.
- R10: While a sequence is in progress, all non-reset requests are ignored, and they do not start a new sequence afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| resetReq | input | 1 | Processor reset request, top priority |
| excReq | input | 1 | Internal exception request |
| excType | input | 8 | Vector type of the exception |
| swReq | input | 1 | Software interrupt request |
| swType | input | 8 | Vector type of the software interrupt |
| nmiReq | input | 1 | Non-maskable interrupt request (type 2) |
| hwReq | input | 1 | Maskable hardware interrupt request |
| hwType | input | 8 | Vector type of the hardware interrupt |
| retReq | input | 1 | Return-from-interrupt request |
| curCs | input | 16 | Current code segment |
| curIp | input | 16 | Current instruction pointer |
| curSs | input | 16 | Current stack segment |
| curSp | input | 16 | Current stack pointer |
| curFlags | input | 16 | Current flags word (bit 9 enable, bit 8 trap) |
| memValid | output | 1 | Memory transfer request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 20 | Byte address of the word |
| memWdata | output | 16 | Write data |
| memReady | input | 1 | Memory accepts the transfer |
| memRdata | input | 16 | Read data, valid with memReady |
| cpuCs | output | 16 | Resulting code segment |
| cpuIp | output | 16 | Resulting instruction pointer |
| cpuSp | output | 16 | Resulting stack pointer |
| cpuFlags | output | 16 | Resulting flags word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench checks priority when several request classes are raised together. A wrong encoder would fetch the vector of a lower-priority class, or start a return in place of an entry.

It raises a masked hardware request with bit 9 clear and expects no activity. It also raises new requests in the middle of a sequence and expects them to be dropped. A design that latched either kind of request would run an extra sequence.

Ready stalls check that the address and data hold. A reset during an entry must stop all bus traffic in the same cycle, or a stray stack write would appear.

Each entry is followed by a return, so the pop order and the SP arithmetic are both checked. A swapped push or pop order, or SP stepped on the wrong side of a transfer, gives wrong restored CS:IP or flags.

// File: rtl/intSeqPkg.sv
package intSeqPkg;
  parameter int WORD_W = 16;
  parameter int TYPE_W = 8;
  parameter int ADDR_W = WORD_W + 4;
  parameter int IF_BIT = 9;
  parameter int TF_BIT = 8;
  parameter logic [TYPE_W-1:0] NMI_TYPE = 8'd2;
  parameter logic [WORD_W-1:0] BOOT_CS = 16'hFFFF;
  parameter logic [WORD_W-1:0] BOOT_IP = 16'h0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PSH_F, ST_PSH_CS, ST_PSH_IP, ST_VEC_IP, ST_VEC_CS,
    ST_POP_IP, ST_POP_CS, ST_POP_F
  } seqState_t;

  typedef enum logic [1:0] {ADR_PUSH, ADR_POP, ADR_VLO, ADR_VHI} adrSel_t;
  typedef enum logic [1:0] {WD_FLAGS, WD_CS, WD_IP} wdSel_t;

  typedef struct packed {
    logic              snap;
    logic [TYPE_W-1:0] vecType;
    logic              goReset;
    logic              spDec;
    logic              spInc;
    adrSel_t           adrSel;
    wdSel_t            wdSel;
    logic              ldIp;
    logic              ldCs;
    logic              ldFlags;
    logic              maskFlags;
  } dpCtl_t;
endpackage

// File: rtl/intSeqCtrl.sv
module intSeqCtrl
  import intSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              excReq,
  input  logic [TYPE_W-1:0] excType,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic              nmiReq,
  input  logic              hwReq,
  input  logic [TYPE_W-1:0] hwType,
  input  logic              retReq,
  input  logic              intEnable,
  input  logic              memReady,
  output dpCtl_t            ctl,
  output logic              memValid,
  output logic              memWrite,
  output logic              busy,
  output logic              done
);
  seqState_t state, nxt;
  logic fire, finish;

  assign busy     = (state != ST_IDLE);
  assign memValid = busy && !resetReq;
  assign memWrite = (state == ST_PSH_F) || (state == ST_PSH_CS) || (state == ST_PSH_IP);
  assign fire     = memValid && memReady;

  always_comb begin
    ctl    = '0;
    nxt    = state;
    finish = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (excReq) begin
          ctl.snap = 1'b1; ctl.vecType = excType; nxt = ST_PSH_F;
        end else if (swReq) begin
          ctl.snap = 1'b1; ctl.vecType = swType; nxt = ST_PSH_F;
        end else if (nmiReq) begin
          ctl.snap = 1'b1; ctl.vecType = NMI_TYPE; nxt = ST_PSH_F;
        end else if (hwReq && intEnable) begin
          ctl.snap = 1'b1; ctl.vecType = hwType; nxt = ST_PSH_F;
        end else if (retReq) begin
          ctl.snap = 1'b1; nxt = ST_POP_IP;
        end
      end
      ST_PSH_F: begin
        ctl.adrSel = ADR_PUSH; ctl.wdSel = WD_FLAGS;
        if (fire) begin ctl.spDec = 1'b1; ctl.maskFlags = 1'b1; nxt = ST_PSH_CS; end
      end
      ST_PSH_CS: begin
        ctl.adrSel = ADR_PUSH; ctl.wdSel = WD_CS;
        if (fire) begin ctl.spDec = 1'b1; nxt = ST_PSH_IP; end
      end
      ST_PSH_IP: begin
        ctl.adrSel = ADR_PUSH; ctl.wdSel = WD_IP;
        if (fire) begin ctl.spDec = 1'b1; nxt = ST_VEC_IP; end
      end
      ST_VEC_IP: begin
        ctl.adrSel = ADR_VLO;
        if (fire) begin ctl.ldIp = 1'b1; nxt = ST_VEC_CS; end
      end
      ST_VEC_CS: begin
        ctl.adrSel = ADR_VHI;
        if (fire) begin ctl.ldCs = 1'b1; nxt = ST_IDLE; finish = 1'b1; end
      end
      ST_POP_IP: begin
        ctl.adrSel = ADR_POP;
        if (fire) begin ctl.ldIp = 1'b1; ctl.spInc = 1'b1; nxt = ST_POP_CS; end
      end
      ST_POP_CS: begin
        ctl.adrSel = ADR_POP;
        if (fire) begin ctl.ldCs = 1'b1; ctl.spInc = 1'b1; nxt = ST_POP_F; end
      end
      ST_POP_F: begin
        ctl.adrSel = ADR_POP;
        if (fire) begin ctl.ldFlags = 1'b1; ctl.spInc = 1'b1; nxt = ST_IDLE; finish = 1'b1; end
      end
      default: nxt = ST_IDLE;
    endcase
    if (resetReq) begin
      ctl         = '0;
      ctl.goReset = 1'b1;
      nxt         = ST_IDLE;
      finish      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
    end
  end
endmodule

// File: rtl/intSeqDp.sv
module intSeqDp
  import intSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] curCs,
  input  logic [WORD_W-1:0] curIp,
  input  logic [WORD_W-1:0] curSs,
  input  logic [WORD_W-1:0] curSp,
  input  logic [WORD_W-1:0] curFlags,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] cpuCs,
  output logic [WORD_W-1:0] cpuIp,
  output logic [WORD_W-1:0] cpuSp,
  output logic [WORD_W-1:0] cpuFlags
);
  localparam int SEG_SHIFT = ADDR_W - WORD_W;
  localparam int VEC_PAD   = ADDR_W - TYPE_W - 2;
  localparam logic [WORD_W-1:0] WORD_BYTES = 2;
  localparam logic [WORD_W-1:0] FLAG_MASK  = (WORD_W'(1) << IF_BIT) | (WORD_W'(1) << TF_BIT);

  logic [WORD_W-1:0] rCs, rIp, rSs, rSp, rFlags;
  logic [TYPE_W-1:0] rType;
  logic [WORD_W-1:0] spDown;
  logic [ADDR_W-1:0] stackBase, vecBase;

  assign spDown    = rSp - WORD_BYTES;
  assign stackBase = {rSs, {SEG_SHIFT{1'b0}}};
  assign vecBase   = {{VEC_PAD{1'b0}}, rType, 2'b00};

  always_comb begin
    unique case (ctl.adrSel)
      ADR_PUSH: memAddr = stackBase + {{SEG_SHIFT{1'b0}}, spDown};
      ADR_POP:  memAddr = stackBase + {{SEG_SHIFT{1'b0}}, rSp};
      ADR_VLO:  memAddr = vecBase;
      default:  memAddr = vecBase + ADDR_W'(2);
    endcase
    unique case (ctl.wdSel)
      WD_FLAGS: memWdata = rFlags;
      WD_CS:    memWdata = rCs;
      default:  memWdata = rIp;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rCs    <= BOOT_CS;
      rIp    <= BOOT_IP;
      rSs    <= '0;
      rSp    <= '0;
      rFlags <= '0;
      rType  <= '0;
    end else if (ctl.goReset) begin
      rCs    <= BOOT_CS;
      rIp    <= BOOT_IP;
      rFlags <= '0;
    end else if (ctl.snap) begin
      rCs    <= curCs;
      rIp    <= curIp;
      rSs    <= curSs;
      rSp    <= curSp;
      rFlags <= curFlags;
      rType  <= ctl.vecType;
    end else begin
      if (ctl.spDec)     rSp    <= spDown;
      if (ctl.spInc)     rSp    <= rSp + WORD_BYTES;
      if (ctl.maskFlags) rFlags <= rFlags & ~FLAG_MASK;
      if (ctl.ldFlags)   rFlags <= memRdata;
      if (ctl.ldIp)      rIp    <= memRdata;
      if (ctl.ldCs)      rCs    <= memRdata;
    end
  end

  assign cpuCs    = rCs;
  assign cpuIp    = rIp;
  assign cpuSp    = rSp;
  assign cpuFlags = rFlags;
endmodule

// File: rtl/intSeq.sv
module intSeq
  import intSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              excReq,
  input  logic [TYPE_W-1:0] excType,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic              nmiReq,
  input  logic              hwReq,
  input  logic [TYPE_W-1:0] hwType,
  input  logic              retReq,
  input  logic [WORD_W-1:0] curCs,
  input  logic [WORD_W-1:0] curIp,
  input  logic [WORD_W-1:0] curSs,
  input  logic [WORD_W-1:0] curSp,
  input  logic [WORD_W-1:0] curFlags,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] cpuCs,
  output logic [WORD_W-1:0] cpuIp,
  output logic [WORD_W-1:0] cpuSp,
  output logic [WORD_W-1:0] cpuFlags,
  output logic              busy,
  output logic              done
);
  dpCtl_t ctl;

  intSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq),
    .excReq(excReq), .excType(excType), .swReq(swReq), .swType(swType),
    .nmiReq(nmiReq), .hwReq(hwReq), .hwType(hwType), .retReq(retReq),
    .intEnable(curFlags[IF_BIT]), .memReady(memReady), .ctl(ctl),
    .memValid(memValid), .memWrite(memWrite), .busy(busy), .done(done)
  );

  intSeqDp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .curCs(curCs), .curIp(curIp), .curSs(curSs), .curSp(curSp), .curFlags(curFlags),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .cpuCs(cpuCs), .cpuIp(cpuIp), .cpuSp(cpuSp), .cpuFlags(cpuFlags)
  );
endmodule

// File: rtl/intSeqChk.sv
module intSeqChk
  import intSeqPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              resetReq,
  input logic              memValid,
  input logic              memReady,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic [WORD_W-1:0] cpuCs,
  input logic [WORD_W-1:0] cpuIp,
  input logic [WORD_W-1:0] cpuSp,
  input logic [WORD_W-1:0] cpuFlags,
  input logic              busy,
  input logic              done
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady && !resetReq) |=> (memValid && $stable(memAddr) && $stable(memWrite) && $stable(memWdata))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memValid); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !resetReq) |=> !done); // R9

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (cpuCs == 16'hFFFF && cpuIp == 16'h0000 && cpuFlags == 16'h0000 && !busy && done)); // R7

  AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && memReady) |=> (cpuSp == $past(cpuSp) - 16'd2)); // R3

  AST_FLAGS_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && memReady) |=> (cpuFlags[IF_BIT] == 1'b0 && cpuFlags[TF_BIT] == 1'b0)); // R4
endmodule

bind intSeq intSeqChk uChk (.*);

// File: tb/tb_intSeq.sv
`timescale 1ns/1ps
module tb_intSeq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, resetReq, excReq, swReq, nmiReq, hwReq, retReq;
  logic [7:0] excType, swType, hwType;
  logic [15:0] curCs, curIp, curSs, curSp, curFlags;
  logic memValid, memWrite, memReady;
  logic [19:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic [15:0] cpuCs, cpuIp, cpuSp, cpuFlags;
  logic busy, done;

  intSeq dut (.*);

  int total = 0, bad = 0;
  bit readyEn = 1'b1;
  logic [15:0] mem [int unsigned];
  int logN = 0;
  logic [19:0] logA [16];
  logic        logW [16];
  logic [15:0] logD [16];

  function automatic logic [15:0] rdVal(input logic [19:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return (a[15:0] * 16'h9E37) ^ 16'h1234;
  endfunction

  always @(negedge clk) begin
    #1;
    memReady = readyEn && (($urandom % 4) != 0);
    memRdata = 16'h0;
    if (memValid && memReady) begin
      if (logN < 16) begin
        logA[logN] = memAddr; logW[logN] = memWrite; logD[logN] = memWdata;
      end
      logN++;
      if (memWrite) mem[int'(memAddr)] = memWdata;
      else memRdata = rdVal(memAddr);
    end
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic clearReqs();
    resetReq = 0; excReq = 0; swReq = 0; nmiReq = 0; hwReq = 0; retReq = 0;
  endtask

  task automatic waitDone(output bit got);
    got = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin got = 1; return; end
    end
  endtask

  // mask bits: 0 exc, 1 sw, 2 nmi, 3 hw, 4 ret
  task automatic runEntry(input logic [4:0] mask, input logic [7:0] tE, input logic [7:0] tS,
                          input logic [7:0] tH, input logic [15:0] cs, input logic [15:0] ip,
                          input logic [15:0] ss, input logic [15:0] sp, input logic [15:0] fl,
                          input bit disturb);
    logic [7:0] ty;
    logic [15:0] sp2;
    bit got;
    if (mask[0]) ty = tE;
    else if (mask[1]) ty = tS;
    else if (mask[2]) ty = 8'd2;
    else ty = tH;
    @(negedge clk);
    logN = 0;
    curCs = cs; curIp = ip; curSs = ss; curSp = sp; curFlags = fl;
    excType = tE; swType = tS; hwType = tH;
    excReq = mask[0]; swReq = mask[1]; nmiReq = mask[2]; hwReq = mask[3]; retReq = mask[4];
    @(negedge clk);
    checkEq("R9 busy after accept", {31'd0, busy}, 32'd1);
    clearReqs();
    if (disturb) begin
      @(negedge clk);
      excReq = 1; swReq = 1; retReq = 1; excType = ~tE; swType = ~tS;
      @(negedge clk);
      clearReqs();
    end
    waitDone(got);
    checkEq("R9 done seen", {31'd0, got}, 32'd1);
    checkEq("R9 busy low with done", {31'd0, busy}, 32'd0);
    checkEq("R2 transfer count", logN, 5);
    sp2 = sp - 16'd2;
    checkEq("R2 R3 flags push addr", logA[0], phys(ss, sp2));
    checkEq("R2 flags push data", {logW[0], logD[0]}, {1'b1, fl});
    sp2 = sp - 16'd4;
    checkEq("R2 R3 cs push addr", logA[1], phys(ss, sp2));
    checkEq("R2 cs push data", {logW[1], logD[1]}, {1'b1, cs});
    sp2 = sp - 16'd6;
    checkEq("R2 R3 ip push addr", logA[2], phys(ss, sp2));
    checkEq("R2 ip push data", {logW[2], logD[2]}, {1'b1, ip});
    checkEq("R1 R5 ip vector read addr", {logW[3], logA[3]}, {1'b0, 10'd0, ty, 2'b00});
    checkEq("R5 cs vector read addr", {logW[4], logA[4]}, {1'b0, 10'd0, ty, 2'b10});
    checkEq("R5 new ip", cpuIp, rdVal({10'd0, ty, 2'b00}));
    checkEq("R5 new cs", cpuCs, rdVal({10'd0, ty, 2'b10}));
    checkEq("R3 new sp", cpuSp, sp - 16'd6);
    checkEq("R4 flags masked", cpuFlags, fl & 16'hFCFF);
    if (disturb) begin
      repeat (4) @(negedge clk);
      checkEq("R10 no extra sequence", {31'd0, busy}, 32'd0);
      checkEq("R10 no extra transfer", logN, 5);
    end
  endtask

  task automatic runReturn(input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] fl);
    logic [15:0] ss, sp;
    bit got;
    @(negedge clk);
    ss = curSs; sp = cpuSp;
    logN = 0;
    curCs = cpuCs; curIp = cpuIp; curSp = sp; curFlags = cpuFlags;
    retReq = 1;
    @(negedge clk);
    clearReqs();
    waitDone(got);
    checkEq("R6 return done", {31'd0, got}, 32'd1);
    checkEq("R6 pop count", logN, 3);
    checkEq("R6 pop ip addr", {logW[0], logA[0]}, {1'b0, phys(ss, sp)});
    checkEq("R6 pop cs addr", {logW[1], logA[1]}, {1'b0, phys(ss, sp + 16'd2)});
    checkEq("R6 pop flags addr", {logW[2], logA[2]}, {1'b0, phys(ss, sp + 16'd4)});
    checkEq("R6 restored ip", cpuIp, ip);
    checkEq("R6 restored cs", cpuCs, cs);
    checkEq("R6 restored flags", cpuFlags, fl);
    checkEq("R6 restored sp", cpuSp, sp + 16'd6);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rstN = 0; clearReqs();
    excType = 0; swType = 0; hwType = 0;
    curCs = 0; curIp = 0; curSs = 16'h0200; curSp = 16'h0100; curFlags = 0;
    memReady = 0; memRdata = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkEq("R7 reset cs", cpuCs, 16'hFFFF);
    checkEq("R7 reset ip", cpuIp, 16'h0000);
    checkEq("R7 reset flags", cpuFlags, 16'h0000);
    checkEq("R7 reset busy done valid", {busy, done, memValid}, 3'b000);

    // priority combinations
    runEntry(5'b11111, 8'h21, 8'h80, 8'h08, 16'h1000, 16'h0010, 16'h0300, 16'h0400, 16'h0302, 0);
    runReturn(16'h1000, 16'h0010, 16'h0302);
    runEntry(5'b11110, 8'h21, 8'h80, 8'h08, 16'h2000, 16'h0020, 16'h0300, 16'h0400, 16'h0200, 0);
    runEntry(5'b11100, 8'h21, 8'h80, 8'h08, 16'h3000, 16'h0030, 16'h0300, 16'h0400, 16'h0200, 0);
    runEntry(5'b11000, 8'h21, 8'h80, 8'h08, 16'h4000, 16'h0040, 16'h0300, 16'h0400, 16'h0200, 0);
    // type 50 vector location
    runEntry(5'b00010, 8'h00, 8'd50, 8'h00, 16'h5000, 16'h0050, 16'h0300, 16'h0400, 16'h0000, 0);
    checkEq("R5 type 50 ip at C8", logA[3], 20'h000C8);
    checkEq("R5 type 50 cs at CA", logA[4], 20'h000CA);

    // masked hardware request
    @(negedge clk);
    logN = 0; curFlags = 16'h0100; hwType = 8'h0F; hwReq = 1;
    repeat (5) begin
      @(negedge clk);
      checkEq("R4 masked hw not busy", {31'd0, busy}, 32'd0);
    end
    hwReq = 0;
    checkEq("R4 masked hw no transfer", logN, 0);

    // requests during a sequence
    runEntry(5'b00001, 8'h33, 8'h44, 8'h55, 16'h6000, 16'h0060, 16'h0400, 16'h0800, 16'h0F00, 1);

    // ready stall holds request
    @(negedge clk);
    readyEn = 0; logN = 0;
    curCs = 16'h7000; curIp = 16'h0070; curSs = 16'h0400; curSp = 16'h0800; curFlags = 16'h0200;
    swType = 8'h11; swReq = 1;
    @(negedge clk);
    clearReqs();
    repeat (6) @(negedge clk);
    checkEq("R8 stalled valid", {busy, memValid, memWrite}, 3'b111);
    checkEq("R8 stalled addr", memAddr, phys(16'h0400, 16'h07FE));
    checkEq("R8 stalled data", memWdata, 16'h0200);
    readyEn = 1;
    begin
      bit got;
      waitDone(got);
      checkEq("R8 completes after stall", {31'd0, got}, 32'd1);
      checkEq("R8 transfers after stall", logN, 5);
    end

    // reset request aborts a sequence
    @(negedge clk);
    curFlags = 16'h0200; nmiReq = 1;
    @(negedge clk);
    nmiReq = 0;
    @(negedge clk);
    resetReq = 1;
    #1.5;
    checkEq("R7 no memValid during reset req", {31'd0, memValid}, 32'd0);
    @(negedge clk);
    resetReq = 0;
    checkEq("R7 abort cs", cpuCs, 16'hFFFF);
    checkEq("R7 abort ip", cpuIp, 16'h0000);
    checkEq("R7 abort flags", cpuFlags, 16'h0000);
    checkEq("R7 abort busy done", {busy, done}, 2'b01);
    @(negedge clk);
    checkEq("R7 stays idle", {busy, done}, 2'b00);

    // random entries and returns
    for (int n = 0; n < 40; n++) begin
      logic [4:0] m;
      logic [15:0] cs, ip, ss, sp, fl;
      m  = 5'($urandom);
      m[4] = 1'b0;
      cs = 16'($urandom); ip = 16'($urandom);
      ss = 16'h0100 + 16'($urandom % 16'hE000);
      sp = 16'h0010 + 16'($urandom % 16'hFF00);
      fl = 16'($urandom);
      if (m[3:0] == 4'b1000 && !fl[9]) m[0] = 1'b1;
      if (m[3:0] == 4'b0000) m[1] = 1'b1;
      runEntry(m, 8'($urandom), 8'($urandom), 8'($urandom), cs, ip, ss, sp, fl, n % 7 == 0);
      runReturn(cs, ip, fl);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule